// File: doc/BRIEF.md
# Aperture Remapping Table Translator

This block remaps a fixed window of input addresses onto physical memory one 4 KiB page at a time. It keeps one table entry per page of the window. A host never addresses the table directly. It first writes an input byte address into a selector register, then reads or writes a data register that stands for the entry of the page holding that address. A one-bit enable in a configuration register gates all translation.

A separate lookup port is used by the client traffic. It accepts an input address and, one clock later, returns either a hit with the translated physical address or a fault. The page offset always passes through unchanged. A physical base comes from any entry whose valid bit (bit 31) is set. Faults are raised for addresses outside the window, for entries whose valid bit is clear, and while translation is disabled. The intended use is that software writes every entry in ascending address order and then enables translation. After that, single entries are mapped or unmapped on the fly.

Top module: `aperture_xlate`

## Requirements
- R1: After reset the configuration register reads 0, every entry reads 0 through the data register, and every lookup faults.
- R2: Register byte offsets are 0x0 for configuration, 0x4 for the entry selector and 0x8 for entry data. Any other offset reads 0 and ignores writes. A read returns `reg_rdata` with `reg_rvalid` high exactly one cycle after `reg_rd`.
- R3: Writing the configuration register stores bit 0 of the written word as the enable. The register reads back as 32'h0000_0001 when enabled and 0 when disabled, whatever the upper bits of the write were.
- R4: The selector register reads back the full word last written to it. An in-window value selects entry (value − base) >> 12, so its low 12 bits do not affect the selection.
- R5: A data-register write stores bit 31 (valid) and bits 30:12 (physical frame) of the word into the selected entry. A data read returns the stored entry with bits 11:0 as zero.
- R6: While the selector holds an out-of-window address, data-register writes change no entry and data-register reads return 0.
- R7: An address is inside the window exactly when base ≤ address ≤ base + PAGE_COUNT×4096 − 1. This holds both for the selector and for lookups.
- R8: A lookup of an in-window address with translation enabled and a valid entry gives `lk_valid` and `lk_hit` one cycle after `lk_req`. `lk_paddr` is then {1'b0, entry bits 30:12, lookup address bits 11:0}.
- R9: A lookup faults (`lk_fault` high, `lk_hit` low, `lk_paddr` zero) when the address is outside the window, the entry valid bit is 0 (even with a non-zero frame field), or translation is disabled.
- R10: Writing an all-zero word to an entry unmaps it. The entry then reads 0 and lookups into its page fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | REG_OFF_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Lookup input address |
| lk_valid | output | 1 | Lookup result valid, one cycle after lk_req |
| lk_hit | output | 1 | Translation succeeded |
| lk_fault | output | 1 | Translation failed |
| lk_paddr | output | ADDR_W | Translated physical address, zero on fault |

## Verification
The lookup path is driven with a vector table of addresses that covers several cases. These are the first and last byte of the window, the bytes just outside each edge, arbitrary page offsets inside mapped pages, a page whose entry has a frame number but a clear valid bit, and a page written with zero. Together they separate range errors from entry-decode errors and from offset-splicing errors. Entries are loaded through selector addresses with non-zero low bits and data words with junk low bits, which exposes index arithmetic that uses the wrong bits and storage that keeps bits it should drop. Directed sequences then toggle the enable, park the selector outside the window and try to write through it, and unmap a live page. Each of these is followed by a read-back or a lookup that would show the disallowed change.

// File: rtl/aperture_pkg.sv
package aperture_pkg;

  // Register select decoded from the host byte offset.
  typedef enum logic [1:0] {
    SEL_CFG   = 2'd0,
    SEL_EADDR = 2'd1,
    SEL_EDATA = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned VALID_BIT = 31;

  function automatic reg_sel_e decode_off(input logic [3:0] off);
    case (off)
      4'h0:    decode_off = SEL_CFG;
      4'h4:    decode_off = SEL_EADDR;
      4'h8:    decode_off = SEL_EDATA;
      default: decode_off = SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/apt_window_check.sv
module apt_window_check #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned PAGE_COUNT = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h4000_0000,
  parameter int unsigned IDX_W      = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win,
  output logic [IDX_W-1:0]  idx
);
  // Bounds carried one bit wider so base + size cannot wrap.
  localparam logic [ADDR_W:0] LO   = {1'b0, WIN_BASE};
  localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(PAGE_COUNT) << PAGE_SHIFT;
  localparam logic [ADDR_W:0] HI   = LO + SPAN - 1'b1;

  logic [ADDR_W:0] wide;
  logic [ADDR_W:0] rel;

  always_comb begin
    wide   = {1'b0, addr};
    in_win = (wide >= LO) && (wide <= HI);
    rel    = wide - LO;
    idx    = IDX_W'(rel >> PAGE_SHIFT);
  end

endmodule

// File: rtl/apt_entry_ram.sv
module apt_entry_ram #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned ENT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  // host port: write and read
  input  logic             a_we,
  input  logic [IDX_W-1:0] a_idx,
  input  logic [ENT_W-1:0] a_wdata,
  output logic [ENT_W-1:0] a_rdata,
  output logic             a_written,
  // lookup port: read only
  input  logic [IDX_W-1:0] b_idx,
  output logic [ENT_W-1:0] b_rdata,
  output logic             b_written
);
  // Payload kept in a reset-free array so it maps onto block RAM;
  // a per-entry written flag in flops gives the all-zero reset view.
  logic [ENT_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0] written_q;

  always_ff @(posedge clk) begin
    if (a_we) mem[a_idx] <= a_wdata;
    a_rdata <= mem[a_idx];
    b_rdata <= mem[b_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written_q <= '0;
      a_written <= 1'b0;
      b_written <= 1'b0;
    end else begin
      if (a_we) written_q[a_idx] <= 1'b1;
      a_written <= written_q[a_idx];
      b_written <= written_q[b_idx];
    end
  end

endmodule

// File: rtl/apt_regfile.sv
module apt_regfile
  import aperture_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned PAGE_COUNT = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h4000_0000,
  parameter int unsigned IDX_W      = 4,
  parameter int unsigned ENT_W      = 20,
  parameter int unsigned REG_OFF_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [REG_OFF_W-1:0] reg_addr,
  input  logic [WORD_W-1:0]    reg_wdata,
  output logic [WORD_W-1:0]    reg_rdata,
  output logic                 reg_rvalid,
  output logic                 xlate_en,
  output logic                 ram_we,
  output logic [IDX_W-1:0]     ram_idx,
  output logic [ENT_W-1:0]     ram_wdata,
  input  logic [ENT_W-1:0]     ram_rdata,
  input  logic                 ram_written
);
  logic              cfg_q;
  logic [WORD_W-1:0] eaddr_q;
  logic              sel_ok;
  reg_sel_e          sel;
  reg_sel_e          rsel_q;
  logic              rok_q;
  logic [WORD_W-1:0] rhold_q;
  logic [WORD_W-1:0] ent_word;

  assign sel = decode_off(4'(reg_addr));

  apt_window_check #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .PAGE_COUNT(PAGE_COUNT),
    .WIN_BASE(WIN_BASE), .IDX_W(IDX_W)
  ) u_sel_win (
    .addr   (ADDR_W'(eaddr_q)),
    .in_win (sel_ok),
    .idx    (ram_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= 1'b0;
      eaddr_q <= '0;
    end else if (reg_wr) begin
      case (sel)
        SEL_CFG:   cfg_q   <= reg_wdata[0];
        SEL_EADDR: eaddr_q <= reg_wdata;
        default:   ;
      endcase
    end
  end

  assign xlate_en  = cfg_q;
  assign ram_we    = reg_wr && (sel == SEL_EDATA) && sel_ok;
  assign ram_wdata = {reg_wdata[VALID_BIT], reg_wdata[VALID_BIT-1:PAGE_SHIFT]};

  // Read pipeline: one cycle. Entry data comes from the RAM output register.
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rvalid <= 1'b0;
      rsel_q     <= SEL_NONE;
      rok_q      <= 1'b0;
      rhold_q    <= '0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) begin
        rsel_q <= sel;
        rok_q  <= sel_ok;
        case (sel)
          SEL_CFG:   rhold_q <= {{(WORD_W-1){1'b0}}, cfg_q};
          SEL_EADDR: rhold_q <= eaddr_q;
          default:   rhold_q <= '0;
        endcase
      end
    end
  end

  assign ent_word = {ram_rdata, {PAGE_SHIFT{1'b0}}};

  always_comb begin
    if (!reg_rvalid)
      reg_rdata = '0;
    else if (rsel_q == SEL_EDATA)
      reg_rdata = (rok_q && ram_written) ? ent_word : '0;
    else
      reg_rdata = rhold_q;
  end

  // R2: read data arrives exactly one cycle after the strobe
  assert_read_latency_R2: assert property (@(posedge clk) disable iff (rst)
    reg_rvalid == $past(reg_rd));

  // R3: enable follows bit 0 of a configuration write
  assert_cfg_write_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && sel == SEL_CFG) |=> (xlate_en == $past(reg_wdata[0])));

  // R6: data read through an out-of-window selector returns zero
  assert_outside_read_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && sel == SEL_EDATA && !sel_ok) |=> (reg_rdata == '0));

  // R2: unmapped offsets read zero
  assert_hole_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && sel == SEL_NONE) |=> (reg_rdata == '0));

endmodule

// File: rtl/apt_lookup.sv
module apt_lookup #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned PAGE_COUNT = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h4000_0000,
  parameter int unsigned IDX_W      = 4,
  parameter int unsigned ENT_W      = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xlate_en,
  input  logic              lk_req,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic [IDX_W-1:0]  ram_idx,
  input  logic [ENT_W-1:0]  ram_rdata,
  input  logic              ram_written,
  output logic              lk_valid,
  output logic              lk_hit,
  output logic              lk_fault,
  output logic [ADDR_W-1:0] lk_paddr
);
  localparam int unsigned PFN_W = ENT_W - 1;

  logic                  in_win;
  logic                  req_q;
  logic                  ok_q;
  logic [PAGE_SHIFT-1:0] off_q;
  logic                  ent_valid;
  logic                  hit;

  apt_window_check #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .PAGE_COUNT(PAGE_COUNT),
    .WIN_BASE(WIN_BASE), .IDX_W(IDX_W)
  ) u_lk_win (
    .addr   (lk_addr),
    .in_win (in_win),
    .idx    (ram_idx)
  );

  // Window and enable are judged in the request cycle, alongside the RAM read.
  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      ok_q  <= 1'b0;
      off_q <= '0;
    end else begin
      req_q <= lk_req;
      ok_q  <= lk_req && in_win && xlate_en;
      off_q <= lk_addr[PAGE_SHIFT-1:0];
    end
  end

  assign ent_valid = ram_written && ram_rdata[ENT_W-1];
  assign hit       = req_q && ok_q && ent_valid;

  assign lk_valid  = req_q;
  assign lk_hit    = hit;
  assign lk_fault  = req_q && !hit;
  assign lk_paddr  = hit ? ADDR_W'({ram_rdata[PFN_W-1:0], off_q}) : '0;

  // R8: response one cycle after request
  assert_resp_latency_R8: assert property (@(posedge clk) disable iff (rst)
    lk_valid == $past(lk_req));

  // R9: every response is exactly one of hit or fault
  assert_hit_xor_fault_R9: assert property (@(posedge clk) disable iff (rst)
    lk_valid |-> (lk_hit != lk_fault));

  // R8: no result flags without a response
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |-> (!lk_hit && !lk_fault));

  // R9: disabled translation never hits
  assert_disabled_faults_R9: assert property (@(posedge clk) disable iff (rst)
    $past(lk_req && !xlate_en) |-> !lk_hit);

  // R8: page offset passes through unchanged on a hit
  assert_offset_pass_R8: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (lk_paddr[PAGE_SHIFT-1:0] == $past(lk_addr[PAGE_SHIFT-1:0])));

  // R9: a fault carries a zero address
  assert_fault_zero_R9: assert property (@(posedge clk) disable iff (rst)
    lk_fault |-> (lk_paddr == '0));

endmodule

// File: rtl/aperture_xlate.sv
module aperture_xlate
  import aperture_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned PAGE_COUNT = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h4000_0000,
  parameter int unsigned REG_OFF_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [REG_OFF_W-1:0] reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic                 reg_rvalid,
  input  logic                 lk_req,
  input  logic [ADDR_W-1:0]    lk_addr,
  output logic                 lk_valid,
  output logic                 lk_hit,
  output logic                 lk_fault,
  output logic [ADDR_W-1:0]    lk_paddr
);
  localparam int unsigned IDX_W = (PAGE_COUNT > 1) ? $clog2(PAGE_COUNT) : 1;
  localparam int unsigned ENT_W = WORD_W - PAGE_SHIFT;   // valid + frame

  logic             xlate_en;
  logic             a_we;
  logic [IDX_W-1:0] a_idx;
  logic [ENT_W-1:0] a_wdata;
  logic [ENT_W-1:0] a_rdata;
  logic             a_written;
  logic [IDX_W-1:0] b_idx;
  logic [ENT_W-1:0] b_rdata;
  logic             b_written;

  apt_regfile #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .PAGE_COUNT(PAGE_COUNT),
    .WIN_BASE(WIN_BASE), .IDX_W(IDX_W), .ENT_W(ENT_W), .REG_OFF_W(REG_OFF_W)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .reg_rvalid (reg_rvalid),
    .xlate_en   (xlate_en),
    .ram_we     (a_we),
    .ram_idx    (a_idx),
    .ram_wdata  (a_wdata),
    .ram_rdata  (a_rdata),
    .ram_written(a_written)
  );

  apt_entry_ram #(
    .DEPTH(PAGE_COUNT), .IDX_W(IDX_W), .ENT_W(ENT_W)
  ) u_table (
    .clk       (clk),
    .rst       (rst),
    .a_we      (a_we),
    .a_idx     (a_idx),
    .a_wdata   (a_wdata),
    .a_rdata   (a_rdata),
    .a_written (a_written),
    .b_idx     (b_idx),
    .b_rdata   (b_rdata),
    .b_written (b_written)
  );

  apt_lookup #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .PAGE_COUNT(PAGE_COUNT),
    .WIN_BASE(WIN_BASE), .IDX_W(IDX_W), .ENT_W(ENT_W)
  ) u_xlate (
    .clk        (clk),
    .rst        (rst),
    .xlate_en   (xlate_en),
    .lk_req     (lk_req),
    .lk_addr    (lk_addr),
    .ram_idx    (b_idx),
    .ram_rdata  (b_rdata),
    .ram_written(b_written),
    .lk_valid   (lk_valid),
    .lk_hit     (lk_hit),
    .lk_fault   (lk_fault),
    .lk_paddr   (lk_paddr)
  );

endmodule

// File: tb/aperture_xlate_tb.sv
`timescale 1ns/1ps
module aperture_xlate_tb_top;
  localparam real         CLK_HALF = 2.5;          // 200 MHz
  localparam logic [31:0] BASE  = 32'h4000_0000;
  localparam int          COUNT = 16;
  localparam logic [31:0] PG    = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        lk_req = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        lk_valid, lk_hit, lk_fault;
  logic [31:0] lk_paddr;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #(CLK_HALF) clk = ~clk;

  aperture_xlate #(.WIN_BASE(BASE), .PAGE_COUNT(COUNT)) dut_i (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .lk_req(lk_req), .lk_addr(lk_addr),
    .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_paddr(lk_paddr)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic        hit;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{32'h4000_0000, 1'b1},   // R7 first byte
    '{32'h4000_0FFF, 1'b1},   // R8 last byte of page 0
    '{32'h4000_1234, 1'b1},   // R8
    '{32'h4000_5010, 1'b0},   // R9 frame set, valid clear
    '{32'h4000_9000, 1'b0},   // R9 entry written zero
    '{32'h4000_FFFF, 1'b1},   // R7 last byte of window
    '{32'h4001_0000, 1'b0},   // R7 one past the end
    '{32'h3FFF_FFFF, 1'b0},   // R7 one below base
    '{32'h4000_A7FE, 1'b1},   // R8
    '{32'h4000_3ABC, 1'b1}    // R8
  };

  // Entry model used to load the table and to predict results.
  function automatic logic [31:0] ent(input int i);
    if (i == 5)      ent = 32'h0012_3000;
    else if (i == 9) ent = 32'h0;
    else             ent = 32'h8000_0000 | ((32'h200 + 32'(i) * 32'h11) << 12);
  endfunction

  function automatic logic [31:0] exp_pa(input logic [31:0] a);
    logic [31:0] e;
    e = ent(int'((a - BASE) >> 12));
    exp_pa = {1'b0, e[30:12], a[11:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] off, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = off; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_read(input logic [3:0] off, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = off;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(reg_rvalid === 1'b1, "R2 rvalid", 32'(reg_rvalid), 32'h1);
    d = reg_rdata;
  endtask

  task automatic lookup(input logic [31:0] a, output logic h, output logic f,
                        output logic [31:0] pa);
    @(negedge clk);
    lk_req = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_req = 1'b0;
    chk(lk_valid === 1'b1, "R8 lk_valid", 32'(lk_valid), 32'h1);
    h = lk_hit; f = lk_fault; pa = lk_paddr;
  endtask

  initial begin
    logic [31:0] d, pa;
    logic        h, f;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    reg_read(4'h0, d);             chk(d == 0, "R1 cfg", d, 0);
    reg_write(4'h4, BASE + 3*PG);
    reg_read(4'h8, d);             chk(d == 0, "R1 entry", d, 0);
    lookup(BASE + 3*PG, h, f, pa); chk(!h && f, "R1 lookup fault", {h, f}, 32'h1);

    // Load all entries in ascending order with junk low bits (R4, R5)
    for (int i = 0; i < COUNT; i++) begin
      reg_write(4'h4, BASE + 32'(i)*PG + ((32'(i)*37) & 32'hFFF));
      reg_write(4'h8, ent(i) | 32'h0000_0ABC);
    end
    for (int i = 3; i < 7; i++) begin
      reg_write(4'h4, BASE + 32'(i)*PG + 32'h7FF);
      reg_read(4'h4, d);  chk(d == BASE + 32'(i)*PG + 32'h7FF, "R4 selector readback", d, BASE + 32'(i)*PG + 32'h7FF);
      reg_read(4'h8, d);  chk(d == ent(i), "R5 entry readback", d, ent(i));
    end

    // R3 enable
    reg_write(4'h0, 32'h1);
    reg_read(4'h0, d);  chk(d == 32'h1, "R3 cfg enabled", d, 32'h1);

    // Vector table on the lookup path (R7, R8, R9)
    foreach (VECS[k]) begin
      lookup(VECS[k].addr, h, f, pa);
      chk(h == VECS[k].hit && f == !VECS[k].hit, "R8/R9 hit-fault", {h, f}, {VECS[k].hit, !VECS[k].hit});
      chk(pa == (VECS[k].hit ? exp_pa(VECS[k].addr) : 32'h0), "R8 paddr", pa,
          VECS[k].hit ? exp_pa(VECS[k].addr) : 32'h0);
    end

    // R2 unmapped offset
    reg_write(4'hC, 32'hFFFF_FFFF);
    reg_read(4'hC, d);  chk(d == 0, "R2 hole", d, 0);
    reg_read(4'h0, d);  chk(d == 32'h1, "R2 hole write ignored", d, 32'h1);

    // R3 upper bits ignored, R9 disabled faults
    reg_write(4'h0, 32'hFFFF_FFFE);
    reg_read(4'h0, d);  chk(d == 0, "R3 cfg disabled", d, 0);
    lookup(BASE + 32'h10, h, f, pa);
    chk(!h && f && pa == 0, "R9 disabled fault", pa, 0);
    reg_write(4'h0, 32'h1);

    // R6 / R7 selector outside window
    reg_write(4'h4, BASE - 1);
    reg_read(4'h8, d);  chk(d == 0, "R6 read below base", d, 0);
    reg_write(4'h8, 32'h8ABC_D000);
    reg_write(4'h4, BASE + 32'(COUNT)*PG);
    reg_read(4'h8, d);  chk(d == 0, "R7 read past end", d, 0);
    reg_write(4'h8, 32'h8ABC_D000);
    reg_write(4'h4, BASE + 2*PG);
    reg_read(4'h8, d);  chk(d == ent(2), "R6 write dropped", d, ent(2));
    reg_write(4'h4, BASE + 15*PG);
    reg_read(4'h8, d);  chk(d == ent(15), "R6 write dropped last", d, ent(15));

    // R10 unmap a live page
    lookup(BASE + 32'h44, h, f, pa); chk(h, "R10 mapped before", {h, f}, 32'h2);
    reg_write(4'h4, BASE);
    reg_write(4'h8, 32'h0);
    reg_read(4'h8, d);  chk(d == 0, "R10 entry cleared", d, 0);
    lookup(BASE + 32'h44, h, f, pa);
    chk(!h && f && pa == 0, "R10 unmapped fault", {h, f}, 32'h1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_HALF * 2.0 * 150000.0);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule